// File: doc/BRIEF.md
# Low-Power Switch-Off Sequencer

This block orders the power-down actions of a mode transition. At a start pulse it captures which resources must be turned off. A resource is turned off when its enable bit is set in the current mode's configuration word and clear in the target mode's word. The resources are the PLL, a set of other clock sources, code flash, data flash, the main regulator and the pad power driver. It then raises one power-down request per resource. Each request waits for its prerequisites, which are done-strobes from the clock-switch, peripheral-clock and core-clock processes outside this block, or the completion of an earlier step.

The PLL is turned off before the other clock sources, so that no source feeding the PLL reference is removed first. Each flash request stays high until the flash ready line drops, with a programmable cycle limit as a backstop. The regulator goes off last, and only when the target is Halt or Stop. A global availability status is kept per resource, and a single done pulse closes the sequence.

Configuration word layout (NCLK = 3 by default): bit 0 PLL enable, bits NCLK:1 clock source enables, bits NCLK+2:NCLK+1 code flash field, bits NCLK+4:NCLK+3 data flash field, bit NCLK+5 regulator enable. Mode codes: TEST=1, SAFE=2, RUN0=4, HALT=8, STOP=10, STANDBY=13. Flash field codes: 00 reserved, 01 power-down, 10 low-power, 11 normal.

Top module: `lp_shutoff_seq`

## Requirements
- R1: After reset, every availability bit is 1 and both flash status fields read 11. No request is high, and busy_o, done_o, flash_tmo_err_o and pads_hiz_o are 0.
- R2: A PLL, clock source or regulator step is needed only if its bit is 1 in the current word and 0 in the target word. A flash step is needed only if the target field is non-zero and numerically lower than the current field. A resource that is not stepped keeps its status.
- R3: The PLL request is a one-cycle pulse in the cycle after sysclk_sw_done_i is sampled while busy. pll_avail_o reads 0 from the following cycle.
- R4: Clock source requests (bit i for source i) pulse one cycle, and only after the system clock switch is done and the PLL step has finished. When the PLL is stepped, this is two cycles after the PLL request. The matching clk_avail_o bits are then cleared.
- R5: A flash request rises in the cycle after core_clk_off_done_i is sampled. It stays high until the flash ready input is sampled low. The status field then takes the target code in the next cycle.
- R6: If flash ready is still high after tmo_lim_i+1 request cycles, the request drops and the status field is written anyway. flash_tmo_err_o is set and then stays 1 until reset.
- R7: The regulator request is issued only for target HALT (8) or STOP (10). It comes only after the PLL and both flash steps have finished, and it clears mvr_avail_o.
- R8: The pad driver request is issued only for target TEST (1), SAFE (2) or STOP (10). It pulses in the cycle after periph_off_done_i is sampled, and it clears pad_avail_o.
- R9: done_o is a single-cycle pulse, raised while busy once every step has finished. When no step is needed it comes in the cycle right after the start is sampled.
- R10: A start pulse while busy_o is high has no effect. The sequence in progress runs to completion on its captured configuration.
- R11: pads_hiz_o rises with the done pulse of a sequence whose target is STANDBY (13). It clears when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle sequence start |
| mode_tgt_i | input | 4 | Target mode code |
| cfg_cur_i | input | NCLK+6 | Current mode configuration word |
| cfg_tgt_i | input | NCLK+6 | Target mode configuration word |
| periph_off_done_i | input | 1 | Peripheral clock disable done strobe |
| sysclk_sw_done_i | input | 1 | System clock switch done strobe |
| core_clk_off_done_i | input | 1 | Processor and memory clock disable done strobe |
| cflash_rdy_i | input | 1 | Code flash ready |
| dflash_rdy_i | input | 1 | Data flash ready |
| tmo_lim_i | input | TMO_W | Flash wait limit in cycles |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete pulse |
| pad_off_req_o | output | 1 | Pad power driver off request |
| pll_off_req_o | output | 1 | PLL power-down request |
| clk_off_req_o | output | NCLK | Clock source power-down requests |
| cflash_lp_req_o | output | 1 | Code flash low-power request |
| dflash_lp_req_o | output | 1 | Data flash low-power request |
| cflash_lp_code_o | output | 2 | Requested code flash state |
| dflash_lp_code_o | output | 2 | Requested data flash state |
| mvr_off_req_o | output | 1 | Main regulator off request |
| pad_avail_o | output | 1 | Pad driver availability |
| pll_avail_o | output | 1 | PLL availability |
| clk_avail_o | output | NCLK | Clock source availability |
| cflash_st_o | output | 2 | Code flash state |
| dflash_st_o | output | 2 | Data flash state |
| mvr_avail_o | output | 1 | Regulator availability |
| flash_tmo_err_o | output | 1 | Sticky flash wait timeout |
| pads_hiz_o | output | 1 | Pads floated for standby |

## Verification
Each request is due exactly one cycle after its last prerequisite is sampled: a done-strobe or the finishing edge of an earlier step. Availability bits change one cycle after the request's last cycle. The bench drives the three strobes on successive cycles and records the cycle counter at each strobe and at each first request cycle, all sampled on the falling edge. It then compares these with the exact offsets: PLL one cycle after the clock-switch strobe, clock sources two after the PLL, flash four request cycles against a ready line that drops after three. Status words are compared only after the done pulse.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam logic [3:0] MODE_TEST    = 4'd1;
  localparam logic [3:0] MODE_SAFE    = 4'd2;
  localparam logic [3:0] MODE_RUN0    = 4'd4;
  localparam logic [3:0] MODE_HALT    = 4'd8;
  localparam logic [3:0] MODE_STOP    = 4'd10;
  localparam logic [3:0] MODE_STANDBY = 4'd13;

  localparam logic [1:0] FLA_RSVD = 2'b00;
  localparam logic [1:0] FLA_PD   = 2'b01;
  localparam logic [1:0] FLA_LP   = 2'b10;
  localparam logic [1:0] FLA_NORM = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_REQ  = 2'd2,
    ST_DONE = 2'd3
  } step_st_e;
endpackage

// File: rtl/lp_need_decode.sv
module lp_need_decode
  import lp_seq_pkg::*;
#(
  parameter int NCLK = 3
) (
  input  logic [NCLK+5:0] cfg_cur_i,
  input  logic [NCLK+5:0] cfg_tgt_i,
  input  logic [3:0]      mode_i,
  output logic            need_pad_o,
  output logic            need_pll_o,
  output logic [NCLK-1:0] need_clk_o,
  output logic [1:0]      need_fla_o,
  output logic            need_mvr_o
);
  localparam int CLK_LO  = 1;
  localparam int CFLA_LO = NCLK + 1;
  localparam int DFLA_LO = NCLK + 3;
  localparam int MVR_B   = NCLK + 5;

  logic [1:0] fla_cur [2];
  logic [1:0] fla_tgt [2];

  assign fla_cur[0] = cfg_cur_i[CFLA_LO +: 2];
  assign fla_cur[1] = cfg_cur_i[DFLA_LO +: 2];
  assign fla_tgt[0] = cfg_tgt_i[CFLA_LO +: 2];
  assign fla_tgt[1] = cfg_tgt_i[DFLA_LO +: 2];

  assign need_pll_o = cfg_cur_i[0] & ~cfg_tgt_i[0];
  assign need_clk_o = cfg_cur_i[CLK_LO +: NCLK] & ~cfg_tgt_i[CLK_LO +: NCLK];

  for (genvar g = 0; g < 2; g++) begin : g_fla
    assign need_fla_o[g] = (fla_tgt[g] != FLA_RSVD) && (fla_tgt[g] < fla_cur[g]);
  end

  assign need_mvr_o = cfg_cur_i[MVR_B] & ~cfg_tgt_i[MVR_B] &
                      ((mode_i == MODE_HALT) | (mode_i == MODE_STOP));

  assign need_pad_o = (mode_i == MODE_SAFE) | (mode_i == MODE_TEST) |
                      (mode_i == MODE_STOP);
endmodule

// File: rtl/lp_step.sv
module lp_step
  import lp_seq_pkg::*;
#(
  parameter bit HAS_WAIT = 1'b0,
  parameter int TMO_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             need_i,
  input  logic             pre_i,
  input  logic             rdy_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  output logic             req_o,
  output logic             fin_o,
  output logic             done_o,
  output logic             tmo_o
);
  step_st_e         st_q;
  logic [TMO_W-1:0] cnt_q;
  logic             cnt_hit;
  logic             wait_ok;

  assign cnt_hit = (cnt_q == tmo_lim_i);
  assign wait_ok = (HAS_WAIT == 1'b0) | ~rdy_i | cnt_hit;
  assign req_o   = (st_q == ST_REQ);
  assign fin_o   = req_o & wait_ok;
  assign done_o  = (st_q == ST_DONE);
  assign tmo_o   = fin_o & rdy_i & (HAS_WAIT == 1'b1);

  if (HAS_WAIT) begin : g_wait
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (st_q != ST_REQ)  cnt_q <= '0;
      else if (!cnt_hit)        cnt_q <= cnt_q + 1'b1;
    end
  end else begin : g_nowait
    assign cnt_q = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else if (clear_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load_i) st_q <= need_i ? ST_PEND : ST_DONE;
        ST_PEND: if (pre_i)  st_q <= ST_REQ;
        ST_REQ:  if (wait_ok) st_q <= ST_DONE;
        default: st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/lp_status_regs.sv
module lp_status_regs
  import lp_seq_pkg::*;
#(
  parameter int NCLK = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fin_pad_i,
  input  logic            fin_pll_i,
  input  logic            fin_clk_i,
  input  logic [NCLK-1:0] clk_mask_i,
  input  logic [1:0]      fin_fla_i,
  input  logic [1:0]      cfla_code_i,
  input  logic [1:0]      dfla_code_i,
  input  logic            fin_mvr_i,
  input  logic            tmo_evt_i,
  output logic            pad_avail_o,
  output logic            pll_avail_o,
  output logic [NCLK-1:0] clk_avail_o,
  output logic [1:0]      cflash_st_o,
  output logic [1:0]      dflash_st_o,
  output logic            mvr_avail_o,
  output logic            tmo_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_avail_o <= 1'b1;
      pll_avail_o <= 1'b1;
      clk_avail_o <= '1;
      cflash_st_o <= FLA_NORM;
      dflash_st_o <= FLA_NORM;
      mvr_avail_o <= 1'b1;
      tmo_err_o   <= 1'b0;
    end else begin
      if (fin_pad_i)    pad_avail_o <= 1'b0;
      if (fin_pll_i)    pll_avail_o <= 1'b0;
      if (fin_clk_i)    clk_avail_o <= clk_avail_o & ~clk_mask_i;
      if (fin_fla_i[0]) cflash_st_o <= cfla_code_i;
      if (fin_fla_i[1]) dflash_st_o <= dfla_code_i;
      if (fin_mvr_i)    mvr_avail_o <= 1'b0;
      if (tmo_evt_i)    tmo_err_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/lp_shutoff_seq.sv
module lp_shutoff_seq
  import lp_seq_pkg::*;
#(
  parameter int NCLK  = 3,
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       mode_tgt_i,
  input  logic [NCLK+5:0]  cfg_cur_i,
  input  logic [NCLK+5:0]  cfg_tgt_i,
  input  logic             periph_off_done_i,
  input  logic             sysclk_sw_done_i,
  input  logic             core_clk_off_done_i,
  input  logic             cflash_rdy_i,
  input  logic             dflash_rdy_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pad_off_req_o,
  output logic             pll_off_req_o,
  output logic [NCLK-1:0]  clk_off_req_o,
  output logic             cflash_lp_req_o,
  output logic             dflash_lp_req_o,
  output logic [1:0]       cflash_lp_code_o,
  output logic [1:0]       dflash_lp_code_o,
  output logic             mvr_off_req_o,
  output logic             pad_avail_o,
  output logic             pll_avail_o,
  output logic [NCLK-1:0]  clk_avail_o,
  output logic [1:0]       cflash_st_o,
  output logic [1:0]       dflash_st_o,
  output logic             mvr_avail_o,
  output logic             flash_tmo_err_o,
  output logic             pads_hiz_o
);
  localparam int CFLA_LO = NCLK + 1;
  localparam int DFLA_LO = NCLK + 3;
  localparam int NSTEP   = 6;

  logic            busy_q, load, seq_done;
  logic            per_q, sys_q, core_q;
  logic            per_ok, sys_ok, core_ok;
  logic [NCLK-1:0] clk_mask_q;
  logic [1:0]      fla_code_q [2];
  logic            stby_q, hiz_q;

  logic            need_pad, need_pll, need_mvr;
  logic [NCLK-1:0] need_clk;
  logic [1:0]      need_fla;

  logic            req_pad, req_pll, req_clk, req_mvr;
  logic            fin_pad, fin_pll, fin_clk, fin_mvr;
  logic            dn_pad, dn_pll, dn_clk, dn_mvr;
  logic [1:0]      req_fla, fin_fla, dn_fla, tmo_fla, rdy_fla;
  logic [NSTEP-1:0] tmo_vec, dn_vec;

  assign load     = start_i & ~busy_q;
  assign dn_vec   = {dn_pad, dn_pll, dn_clk, dn_fla, dn_mvr};
  assign seq_done = busy_q & (&dn_vec);

  // strobe seen now or latched earlier in this sequence
  assign per_ok  = per_q  | periph_off_done_i;
  assign sys_ok  = sys_q  | sysclk_sw_done_i;
  assign core_ok = core_q | core_clk_off_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q        <= 1'b0;
      per_q         <= 1'b0;
      sys_q         <= 1'b0;
      core_q        <= 1'b0;
      clk_mask_q    <= '0;
      fla_code_q[0] <= FLA_NORM;
      fla_code_q[1] <= FLA_NORM;
      stby_q        <= 1'b0;
      hiz_q         <= 1'b0;
    end else if (load) begin
      busy_q        <= 1'b1;
      per_q         <= 1'b0;
      sys_q         <= 1'b0;
      core_q        <= 1'b0;
      clk_mask_q    <= need_clk;
      fla_code_q[0] <= cfg_tgt_i[CFLA_LO +: 2];
      fla_code_q[1] <= cfg_tgt_i[DFLA_LO +: 2];
      stby_q        <= (mode_tgt_i == MODE_STANDBY);
      hiz_q         <= 1'b0;
    end else if (busy_q) begin
      per_q  <= per_ok;
      sys_q  <= sys_ok;
      core_q <= core_ok;
      if (seq_done) begin
        busy_q <= 1'b0;
        hiz_q  <= stby_q;
      end
    end
  end

  lp_need_decode #(.NCLK(NCLK)) u_dec (
    .cfg_cur_i  (cfg_cur_i),
    .cfg_tgt_i  (cfg_tgt_i),
    .mode_i     (mode_tgt_i),
    .need_pad_o (need_pad),
    .need_pll_o (need_pll),
    .need_clk_o (need_clk),
    .need_fla_o (need_fla),
    .need_mvr_o (need_mvr)
  );

  lp_step #(.HAS_WAIT(1'b0), .TMO_W(TMO_W)) u_pad (
    .clk_i, .rst_ni, .clear_i(seq_done), .load_i(load), .need_i(need_pad),
    .pre_i(per_ok), .rdy_i(1'b0), .tmo_lim_i,
    .req_o(req_pad), .fin_o(fin_pad), .done_o(dn_pad), .tmo_o(tmo_vec[0])
  );

  lp_step #(.HAS_WAIT(1'b0), .TMO_W(TMO_W)) u_pll (
    .clk_i, .rst_ni, .clear_i(seq_done), .load_i(load), .need_i(need_pll),
    .pre_i(sys_ok), .rdy_i(1'b0), .tmo_lim_i,
    .req_o(req_pll), .fin_o(fin_pll), .done_o(dn_pll), .tmo_o(tmo_vec[1])
  );

  // sources go after the PLL so its reference is never pulled first
  lp_step #(.HAS_WAIT(1'b0), .TMO_W(TMO_W)) u_clk (
    .clk_i, .rst_ni, .clear_i(seq_done), .load_i(load), .need_i(|need_clk),
    .pre_i(sys_ok & dn_pll), .rdy_i(1'b0), .tmo_lim_i,
    .req_o(req_clk), .fin_o(fin_clk), .done_o(dn_clk), .tmo_o(tmo_vec[2])
  );

  assign rdy_fla = {dflash_rdy_i, cflash_rdy_i};

  for (genvar g = 0; g < 2; g++) begin : g_fla
    lp_step #(.HAS_WAIT(1'b1), .TMO_W(TMO_W)) u_fla (
      .clk_i, .rst_ni, .clear_i(seq_done), .load_i(load), .need_i(need_fla[g]),
      .pre_i(core_ok), .rdy_i(rdy_fla[g]), .tmo_lim_i,
      .req_o(req_fla[g]), .fin_o(fin_fla[g]), .done_o(dn_fla[g]), .tmo_o(tmo_fla[g])
    );
  end

  assign tmo_vec[4:3] = tmo_fla;

  lp_step #(.HAS_WAIT(1'b0), .TMO_W(TMO_W)) u_mvr (
    .clk_i, .rst_ni, .clear_i(seq_done), .load_i(load), .need_i(need_mvr),
    .pre_i(dn_pll & (&dn_fla)), .rdy_i(1'b0), .tmo_lim_i,
    .req_o(req_mvr), .fin_o(fin_mvr), .done_o(dn_mvr), .tmo_o(tmo_vec[5])
  );

  lp_status_regs #(.NCLK(NCLK)) u_st (
    .clk_i, .rst_ni,
    .fin_pad_i   (fin_pad),
    .fin_pll_i   (fin_pll),
    .fin_clk_i   (fin_clk),
    .clk_mask_i  (clk_mask_q),
    .fin_fla_i   (fin_fla),
    .cfla_code_i (fla_code_q[0]),
    .dfla_code_i (fla_code_q[1]),
    .fin_mvr_i   (fin_mvr),
    .tmo_evt_i   (|tmo_vec),
    .pad_avail_o,
    .pll_avail_o,
    .clk_avail_o,
    .cflash_st_o,
    .dflash_st_o,
    .mvr_avail_o,
    .tmo_err_o   (flash_tmo_err_o)
  );

  assign busy_o           = busy_q;
  assign done_o           = seq_done;
  assign pad_off_req_o    = req_pad;
  assign pll_off_req_o    = req_pll;
  assign clk_off_req_o    = {NCLK{req_clk}} & clk_mask_q;
  assign cflash_lp_req_o  = req_fla[0];
  assign dflash_lp_req_o  = req_fla[1];
  assign cflash_lp_code_o = fla_code_q[0];
  assign dflash_lp_code_o = fla_code_q[1];
  assign mvr_off_req_o    = req_mvr;
  assign pads_hiz_o       = hiz_q;
endmodule

// File: rtl/lp_shutoff_seq_chk.sv
module lp_shutoff_seq_chk #(
  parameter int NCLK = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            pad_off_req_o,
  input logic            pll_off_req_o,
  input logic [NCLK-1:0] clk_off_req_o,
  input logic            cflash_lp_req_o,
  input logic            dflash_lp_req_o,
  input logic            mvr_off_req_o,
  input logic            pll_avail_o,
  input logic            flash_tmo_err_o
);
  // R3
  pll_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_off_req_o |=> !pll_off_req_o);

  // R3
  pll_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_off_req_o |=> !pll_avail_o);

  // R4
  clk_after_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clk_off_req_o) |-> (!pll_off_req_o && busy_o));

  // R5
  flash_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cflash_lp_req_o || dflash_lp_req_o) |-> busy_o);

  // R6
  tmo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_tmo_err_o |=> flash_tmo_err_o);

  // R7
  mvr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mvr_off_req_o |-> (!pll_off_req_o && !cflash_lp_req_o && !dflash_lp_req_o));

  // R8
  pad_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_off_req_o |-> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

bind lp_shutoff_seq lp_shutoff_seq_chk #(.NCLK(NCLK)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .pad_off_req_o   (pad_off_req_o),
  .pll_off_req_o   (pll_off_req_o),
  .clk_off_req_o   (clk_off_req_o),
  .cflash_lp_req_o (cflash_lp_req_o),
  .dflash_lp_req_o (dflash_lp_req_o),
  .mvr_off_req_o   (mvr_off_req_o),
  .pll_avail_o     (pll_avail_o),
  .flash_tmo_err_o (flash_tmo_err_o)
);

// File: tb/lp_shutoff_seq_tb_top.sv
module lp_shutoff_seq_tb_top;
  localparam int NCLK  = 3;
  localparam int CFG_W = NCLK + 6;
  localparam int TMO_W = 8;
  localparam int NVEC  = 7;

  // {mode[31:28], cur[27:19], tgt[18:10], exp_status[9:1], pad_stepped[0]}
  // status/cfg layout: [8] mvr, [7:6] dflash, [5:4] cflash, [3:1] clk, [0] pll
  localparam logic [31:0] VECS [NVEC] = '{
    {4'd4,  9'h1FF, 9'h1FF, 9'h1FF, 1'b0},
    {4'd8,  9'h1FF, 9'h06A, 9'h06A, 1'b0},
    {4'd10, 9'h1FF, 9'h050, 9'h050, 1'b1},
    {4'd2,  9'h1FF, 9'h0FF, 9'h1FF, 1'b1},
    {4'd4,  9'h1FE, 9'h1FF, 9'h1FF, 1'b0},
    {4'd1,  9'h1FF, 9'h137, 9'h1F7, 1'b1},
    {4'd8,  9'h17F, 9'h1FF, 9'h1FF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = 4'd4;
  logic [CFG_W-1:0] cfg_cur = '1, cfg_tgt = '1;
  logic per_s = 1'b0, sys_s = 1'b0, core_s = 1'b0;
  logic [TMO_W-1:0] lim = 8'd255;
  logic cf_stuck = 1'b0;
  logic [7:0] cf_cnt = 8'd0, df_cnt = 8'd0;
  logic cf_rdy, df_rdy;

  logic busy, done, pad_req, pll_req, cf_req, df_req, mvr_req;
  logic [NCLK-1:0] clk_req, clk_av;
  logic [1:0] cf_code, df_code, cf_st, df_st;
  logic pad_av, pll_av, mvr_av, tmo_err, hiz;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int t_start, t_per, t_sys, t_core;
  int t_pll, t_clk, t_pad, t_mvr, t_cf, t_cf_last, t_df_last, t_done;
  int cf_cycles, done_cnt;

  always #10 clk = ~clk;

  lp_shutoff_seq #(.NCLK(NCLK), .TMO_W(TMO_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_tgt_i(mode),
    .cfg_cur_i(cfg_cur), .cfg_tgt_i(cfg_tgt),
    .periph_off_done_i(per_s), .sysclk_sw_done_i(sys_s), .core_clk_off_done_i(core_s),
    .cflash_rdy_i(cf_rdy), .dflash_rdy_i(df_rdy), .tmo_lim_i(lim),
    .busy_o(busy), .done_o(done), .pad_off_req_o(pad_req), .pll_off_req_o(pll_req),
    .clk_off_req_o(clk_req), .cflash_lp_req_o(cf_req), .dflash_lp_req_o(df_req),
    .cflash_lp_code_o(cf_code), .dflash_lp_code_o(df_code), .mvr_off_req_o(mvr_req),
    .pad_avail_o(pad_av), .pll_avail_o(pll_av), .clk_avail_o(clk_av),
    .cflash_st_o(cf_st), .dflash_st_o(df_st), .mvr_avail_o(mvr_av),
    .flash_tmo_err_o(tmo_err), .pads_hiz_o(hiz)
  );

  // flash model: ready drops three cycles into a request
  assign cf_rdy = cf_stuck | (cf_cnt < 8'd3);
  assign df_rdy = (df_cnt < 8'd3);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) begin
      cf_cnt <= 8'd0;
      df_cnt <= 8'd0;
    end else begin
      if (cf_req && cf_cnt != 8'hFF) cf_cnt <= cf_cnt + 8'd1;
      if (df_req && df_cnt != 8'hFF) df_cnt <= df_cnt + 8'd1;
    end
  end

  always @(negedge clk) begin
    if (pll_req && t_pll == 0) t_pll = cyc;
    if ((|clk_req) && t_clk == 0) t_clk = cyc;
    if (pad_req && t_pad == 0) t_pad = cyc;
    if (mvr_req && t_mvr == 0) t_mvr = cyc;
    if (cf_req) begin
      if (t_cf == 0) t_cf = cyc;
      t_cf_last = cyc;
      cf_cycles++;
    end
    if (df_req) t_df_last = cyc;
    if (done) begin
      done_cnt++;
      t_done = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr_rec();
    t_pll = 0; t_clk = 0; t_pad = 0; t_mvr = 0; t_cf = 0;
    t_cf_last = 0; t_df_last = 0; t_done = 0; cf_cycles = 0; done_cnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0; per_s = 1'b0; sys_s = 1'b0; core_s = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_seq(input logic [3:0] m, input logic [CFG_W-1:0] c,
                         input logic [CFG_W-1:0] t, input bit poke);
    @(negedge clk);
    mode = m; cfg_cur = c; cfg_tgt = t;
    clr_rec();
    start = 1'b1; t_start = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      mode = 4'd10; cfg_tgt = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    per_s = 1'b1; t_per = cyc;
    @(negedge clk);
    per_s = 1'b0; sys_s = 1'b1; t_sys = cyc;
    @(negedge clk);
    sys_s = 1'b0; core_s = 1'b1; t_core = cyc;
    @(negedge clk);
    core_s = 1'b0;
    for (int k = 0; k < 600; k++) begin
      if (done_cnt > 0 && !busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    clr_rec();
    do_reset();

    // R1 reset state
    chk({mvr_av, df_st, cf_st, clk_av, pll_av} == 9'h1FF, "R1 status",
        int'({mvr_av, df_st, cf_st, clk_av, pll_av}), 'h1FF);
    chk(pad_av == 1'b1, "R1 pad_avail", int'(pad_av), 1);
    chk({busy, done, tmo_err, hiz} == 4'b0, "R1 flags", int'({busy, done, tmo_err, hiz}), 0);
    chk({pad_req, pll_req, clk_req, cf_req, df_req, mvr_req} == '0, "R1 requests",
        int'({pad_req, pll_req, clk_req, cf_req, df_req, mvr_req}), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VECS[i];
      do_reset();
      run_seq(v[31:28], v[27:19], v[18:10], 1'b0);
      // R2 R7 R8: final status per the requirement decode
      chk({mvr_av, df_st, cf_st, clk_av, pll_av} == v[9:1], "R2 status word",
          int'({mvr_av, df_st, cf_st, clk_av, pll_av}), int'(v[9:1]));
      chk(pad_av == !v[0], "R8 pad_avail", int'(pad_av), int'(!v[0]));
      chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
      chk(tmo_err == 1'b0, "R6 no timeout", int'(tmo_err), 0);
      if (i == 0) chk(t_done == t_start + 1, "R9 empty sequence done", t_done, t_start + 1);
      if (t_pll != 0) chk(t_pll == t_sys + 1, "R3 pll request cycle", t_pll, t_sys + 1);
      if (t_clk != 0 && t_pll != 0)
        chk(t_clk == t_pll + 2, "R4 clock source after pll", t_clk, t_pll + 2);
      if (t_clk != 0) chk(t_clk > t_sys, "R4 clock source after switch", t_clk, t_sys + 1);
      if (t_pad != 0) chk(t_pad == t_per + 1, "R8 pad request cycle", t_pad, t_per + 1);
      if (t_cf != 0) begin
        chk(t_cf == t_core + 1, "R5 flash request cycle", t_cf, t_core + 1);
        chk(cf_cycles == 4, "R5 flash held until ready low", cf_cycles, 4);
      end
      if (t_mvr != 0) begin
        chk(t_mvr > t_cf_last && t_mvr > t_df_last && t_mvr > t_pll,
            "R7 regulator last", t_mvr, t_cf_last + 1);
      end
      if (v[31:28] == 4'd8 && v[27:19] == 9'h1FF)
        chk(t_mvr != 0, "R7 regulator stepped in halt", t_mvr, 1);
    end

    // R6 timeout with ready stuck high
    do_reset();
    lim = 8'd5; cf_stuck = 1'b1;
    run_seq(4'd8, 9'h1FF, 9'h06A, 1'b0);
    chk(cf_cycles == 6, "R6 request length at limit", cf_cycles, 6);
    chk(tmo_err == 1'b1, "R6 timeout flag", int'(tmo_err), 1);
    chk(cf_st == 2'b10, "R6 status written on timeout", int'(cf_st), 2);
    chk(done_cnt == 1, "R6 sequence still completes", done_cnt, 1);
    cf_stuck = 1'b0; lim = 8'd255;
    run_seq(4'd4, 9'h1FF, 9'h1FF, 1'b0);
    chk(tmo_err == 1'b1, "R6 timeout sticky", int'(tmo_err), 1);

    // R10 start while busy is ignored
    do_reset();
    run_seq(4'd4, 9'h1FF, 9'h1FE, 1'b1);
    chk({mvr_av, df_st, cf_st, clk_av, pll_av} == 9'h1FE, "R10 second start ignored",
        int'({mvr_av, df_st, cf_st, clk_av, pll_av}), 'h1FE);
    chk(pad_av == 1'b1 && t_pad == 0, "R10 no pad step", int'(pad_av), 1);

    // R11 standby floats pads, next start clears
    do_reset();
    run_seq(4'd13, 9'h1FF, 9'h1FF, 1'b0);
    chk(hiz == 1'b1, "R11 pads floated", int'(hiz), 1);
    chk(t_pad == 0 && pad_av == 1'b1, "R11 no pad driver step", t_pad, 0);
    mode = 4'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && hiz == 1'b0, "R11 cleared on start", int'(hiz), 0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule